// File: doc/BRIEF.md
# Latching SPI Shift-Out Transmitter

This block sends bytes as an SPI master into a chain of serial-in, parallel-out registers that each have a separate storage stage. The writer places one byte at a time into a one-deep holding register and watches a transmit-empty flag to know when the next byte may go in. A write never stalls. The block produces the serial clock and the data line. It also drives an active-low select that doubles as the storage clock of the register chain.

Select falls when the first byte of a frame moves into the shifter. It stays low for as long as the writer refills the holding register before the current byte completes. Because of this, a frame of several bytes goes out as one continuous bit stream. When the last bit has shifted out and no byte is waiting, busy drops. Select rises on the next cycle, and that rising edge copies the shifted data to the chain's parallel outputs. Select then stays high for a programmable minimum time before a new frame can begin.

Top module: `spi_latch_tx`

## Requirements
- R1: After reset, select is high, the serial clock and data are low, busy is low and transmit-empty is high.
- R2: The serial clock period is CLK_DIV system cycles, with the clock low for the first half and high for the second half. The serial clock stays low whenever select is high.
- R3: Each byte is sent as DATA_W bits, most significant bit first. Every bit is presented for exactly one rising serial-clock edge.
- R4: The data line changes only while the serial clock is low, so it is stable across each rising edge.
- R5: A write accepted from idle drives transmit-empty low on the next cycle. Transmit-empty returns high one cycle later, when the byte moves into the shifter. While transmit-empty is low, busy is high.
- R6: A write made while transmit-empty is low is ignored, and the frame carries only the byte already held.
- R7: A byte written while the previous byte is still shifting follows it with no gap. Consecutive rising edges stay exactly CLK_DIV cycles apart across the byte boundary, and the whole frame sits under one select assertion.
- R8: Busy stays high until the last bit's period ends. Select rises exactly one cycle after busy falls.
- R9: Select falls in the cycle a held byte enters the shifter, which is CLK_DIV/2 cycles before the first rising edge. Between frames, select stays high for at least CS_GAP+1 cycles.
- R10: After a frame of N bytes, the chain's storage outputs hold the bytes with the first-written byte farthest along the chain. They are updated once per frame, on select's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to transmit |
| txe_o | output | 1 | Holding register empty; a write is accepted |
| busy_o | output | 1 | A byte is held or is shifting |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Active-low select and storage-register clock |

## Verification
The bench builds the block with CLK_DIV=4, DATA_W=8, MSB first and CS_GAP=2, and models a three-stage chain of 8-bit registers with storage stages. A divider of 4 keeps each bit only four cycles long. This places the refill race, where a byte is written while the prior one is mid-shift, within easy reach of a directed writer. A gap of 2 gives select's minimum high time a distinct, countable value. It also lets a byte written during the latch cycle start a second frame at the earliest legal cycle.

// File: rtl/spi_latch_pkg.sv
`timescale 1ns/1ps
package spi_latch_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_LATCH = 2'd2
   } seq_state_t;

   function automatic int unsigned width_of(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/spi_latch_txbuf.sv
`timescale 1ns/1ps
module spi_latch_txbuf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              take_i,
   output logic              full_o,
   output logic [DATA_W-1:0] data_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_o <= 1'b0;
         data_o <= '0;
      end else if (take_i) begin
         full_o <= 1'b0;
      end else if (wr_en_i && !full_o) begin
         full_o <= 1'b1;
         data_o <= wr_data_i;
      end
   end

endmodule

// File: rtl/spi_latch_bitorder.sv
`timescale 1ns/1ps
module spi_latch_bitorder #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic [DATA_W-1:0] word_i,
   output logic              bit_o,
   output logic [DATA_W-1:0] next_o
);

   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_o  = word_i[DATA_W-1];
         assign next_o = {word_i[DATA_W-2:0], 1'b0};
      end else begin : g_lsb
         assign bit_o  = word_i[0];
         assign next_o = {1'b0, word_i[DATA_W-1:1]};
      end
   endgenerate

endmodule

// File: rtl/spi_latch_seq.sv
`timescale 1ns/1ps
module spi_latch_seq
   import spi_latch_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CLK_DIV   = 4,
   parameter int unsigned CS_GAP    = 2,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              buf_full_i,
   input  logic [DATA_W-1:0] buf_data_i,
   output logic              take_o,
   output logic              busy_o,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              cs_n_o
);

   localparam int unsigned PH_W  = width_of(CLK_DIV);
   localparam int unsigned BIT_W = width_of(DATA_W);
   localparam int unsigned GAP_W = width_of(CS_GAP + 1);
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_DIV - 1);
   localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(CLK_DIV / 2);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);
   localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(CS_GAP);

   seq_state_t        st_q;
   logic [PH_W-1:0]   ph_q;
   logic [BIT_W-1:0]  bitn_q;
   logic [GAP_W-1:0]  gap_q;
   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] shreg_next;
   logic              cur_bit;
   logic              bit_end;
   logic              byte_end;
   logic              start_ok;

   spi_latch_bitorder #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_order (
      .word_i (shreg_q),
      .bit_o  (cur_bit),
      .next_o (shreg_next)
   );

   assign bit_end  = (st_q == ST_SHIFT) && (ph_q == PH_LAST);
   assign byte_end = bit_end && (bitn_q == BIT_LAST);
   assign start_ok = (st_q == ST_IDLE) && (gap_q == '0);
   assign take_o   = buf_full_i && (start_ok || byte_end);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         ph_q    <= '0;
         bitn_q  <= '0;
         gap_q   <= '0;
         shreg_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (gap_q != '0) begin
                  gap_q <= gap_q - 1'b1;
               end else if (buf_full_i) begin
                  st_q    <= ST_SHIFT;
                  ph_q    <= '0;
                  bitn_q  <= '0;
                  shreg_q <= buf_data_i;
               end
            end
            ST_SHIFT: begin
               if (ph_q == PH_LAST) begin
                  ph_q <= '0;
                  if (bitn_q == BIT_LAST) begin
                     if (buf_full_i) begin
                        shreg_q <= buf_data_i;
                        bitn_q  <= '0;
                     end else begin
                        st_q <= ST_LATCH;
                     end
                  end else begin
                     bitn_q  <= bitn_q + 1'b1;
                     shreg_q <= shreg_next;
                  end
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            ST_LATCH: begin
               st_q  <= ST_IDLE;
               gap_q <= GAP_LOAD;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n_o = (st_q == ST_IDLE);
   assign sck_o  = (st_q == ST_SHIFT) && (ph_q >= PH_HALF);
   assign mosi_o = (st_q == ST_SHIFT) && cur_bit;
   assign busy_o = (st_q == ST_SHIFT) || buf_full_i;

endmodule

// File: rtl/spi_latch_tx.sv
`timescale 1ns/1ps
module spi_latch_tx #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CLK_DIV   = 4,
   parameter int unsigned CS_GAP    = 2,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              txe_o,
   output logic              busy_o,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              cs_n_o
);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("spi_latch_tx: CLK_DIV must be even and at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_latch_tx: DATA_W must be at least 2");
      end
   endgenerate

   logic              buf_full;
   logic [DATA_W-1:0] buf_data;
   logic              take;

   spi_latch_txbuf #(
      .DATA_W (DATA_W)
   ) u_buf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .take_i    (take),
      .full_o    (buf_full),
      .data_o    (buf_data)
   );

   spi_latch_seq #(
      .DATA_W    (DATA_W),
      .CLK_DIV   (CLK_DIV),
      .CS_GAP    (CS_GAP),
      .MSB_FIRST (MSB_FIRST)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .buf_full_i (buf_full),
      .buf_data_i (buf_data),
      .take_o     (take),
      .busy_o     (busy_o),
      .sck_o      (sck_o),
      .mosi_o     (mosi_o),
      .cs_n_o     (cs_n_o)
   );

   assign txe_o = !buf_full;

endmodule

// File: rtl/spi_latch_tx_chk.sv
`timescale 1ns/1ps
module spi_latch_tx_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic txe_o,
   input logic busy_o,
   input logic sck_o,
   input logic mosi_o,
   input logic cs_n_o
);

   p_sck_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_n_o |-> !sck_o);

   p_mosi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sck_o) |-> $stable(mosi_o));

   p_full_is_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !txe_o |-> busy_o);

   p_latch_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cs_n_o) |-> $past(!busy_o));

   p_select_needs_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cs_n_o) |-> $past(!txe_o));

endmodule

bind spi_latch_tx spi_latch_tx_chk u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .txe_o  (txe_o),
   .busy_o (busy_o),
   .sck_o  (sck_o),
   .mosi_o (mosi_o),
   .cs_n_o (cs_n_o)
);

// File: tb/spi_latch_tx_tb.sv
`timescale 1ns/1ps
module spi_latch_tx_tb;

   localparam int unsigned DATA_W  = 8;
   localparam int unsigned CLK_DIV = 4;
   localparam int unsigned CS_GAP  = 2;
   localparam int unsigned CHAIN_W = 3 * DATA_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              txe, busy, sck, mosi, cs_n;

   int n_chk = 0;
   int n_fail = 0;

   // chain model and port monitor state
   logic [CHAIN_W-1:0] chain = '0;
   logic [CHAIN_W-1:0] stor = '0;
   logic p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, p_busy = 1'b0;
   int cyc = 0, bits = 0, last_bits = 0, latches = 0;
   int first_rise = 0, last_rise = 0, cs_fall_cyc = 0, cs_rise_cyc = 0;
   int busy_fall_cyc = 0, hi_cnt = 0, last_hi = 0;
   int period_bad = 0, mosi_bad = 0, idle_bad = 0;

   always #2.5 clk = ~clk;

   spi_latch_tx #(
      .DATA_W    (DATA_W),
      .CLK_DIV   (CLK_DIV),
      .CS_GAP    (CS_GAP),
      .MSB_FIRST (1'b1)
   ) u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .txe_o     (txe),
      .busy_o    (busy),
      .sck_o     (sck),
      .mosi_o    (mosi),
      .cs_n_o    (cs_n)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         cyc <= cyc + 1;
         if (cs_n && sck) idle_bad <= idle_bad + 1;
         if (sck && !p_sck) begin
            chain <= {chain[CHAIN_W-2:0], mosi};
            if (mosi !== p_mosi) mosi_bad <= mosi_bad + 1;
            if (bits == 0) first_rise <= cyc;
            else if (cyc - last_rise != CLK_DIV) period_bad <= period_bad + 1;
            last_rise <= cyc;
            bits <= bits + 1;
         end
         if (!cs_n && p_cs) begin
            cs_fall_cyc <= cyc;
            bits <= 0;
            last_hi <= hi_cnt;
            hi_cnt <= 0;
         end else if (cs_n) begin
            hi_cnt <= hi_cnt + 1;
         end
         if (cs_n && !p_cs) begin
            stor <= chain;
            cs_rise_cyc <= cyc;
            last_bits <= bits;
            latches <= latches + 1;
         end
         if (!busy && p_busy) busy_fall_cyc <= cyc;
         p_sck <= sck; p_cs <= cs_n; p_mosi <= mosi; p_busy <= busy;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a falling edge of clk
   task automatic put_byte(input logic [DATA_W-1:0] b);
      while (!txe) @(negedge clk);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!cs_n || busy) @(negedge clk);
      repeat (CS_GAP + 4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 reset outputs {cs_n,sck,mosi,busy,txe}",
          {27'd0, cs_n, sck, mosi, busy, txe}, 32'b10001);
   endtask

   task automatic t_single();
      int l0 = latches;
      put_byte(8'hA5);
      wait_idle();
      chk("R3 single byte on chain", stor[7:0], 8'hA5);
      chk("R3 bits per byte", last_bits, DATA_W);
      chk("R10 one latch per frame", latches - l0, 1);
      chk("R9 select to first rising edge", first_rise - cs_fall_cyc, CLK_DIV / 2);
      chk("R8 select rises one cycle after busy", cs_rise_cyc - busy_fall_cyc, 1);
   endtask

   task automatic t_txe();
      wr_en = 1'b1; wr_data = 8'h3C;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R5 txe low after write", txe, 0);
      chk("R5 busy while byte held", busy, 1);
      @(negedge clk);
      chk("R5 txe back high on move to shifter", txe, 1);
      wait_idle();
      chk("R5 byte delivered", stor[7:0], 8'h3C);
   endtask

   task automatic t_overrun();
      wr_en = 1'b1; wr_data = 8'hC3;
      @(negedge clk);
      wr_data = 8'h99;
      @(negedge clk);
      wr_en = 1'b0;
      wait_idle();
      chk("R6 write while full ignored, bits", last_bits, DATA_W);
      chk("R6 write while full ignored, data", stor[15:0], {8'h3C, 8'hC3});
   endtask

   task automatic t_multi();
      int l0 = latches;
      put_byte(8'h12);
      put_byte(8'h34);
      put_byte(8'h56);
      wait_idle();
      chk("R10 three-byte chain contents", stor, 24'h123456);
      chk("R7 frame bit count", last_bits, 3 * DATA_W);
      chk("R7 single select assertion", latches - l0, 1);
      chk("R7 no gap across bytes", last_rise - first_rise, (3 * DATA_W - 1) * CLK_DIV);
      chk("R8 select rises one cycle after busy", cs_rise_cyc - busy_fall_cyc, 1);
   endtask

   task automatic t_gap();
      int l0 = latches;
      put_byte(8'h0F);
      while (busy) @(negedge clk);
      put_byte(8'hF0);
      wait_idle();
      chk("R9 select high time between frames", last_hi, CS_GAP + 1);
      chk("R9 two frames latched", latches - l0, 2);
      chk("R10 chain after two frames", stor[15:0], 16'h0FF0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_txe();
      t_overrun();
      t_multi();
      t_gap();
      chk("R2 rising edges CLK_DIV apart", period_bad, 0);
      chk("R2 clock low while deselected", idle_bad, 0);
      chk("R4 data stable at rising edge", mosi_bad, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule